// File: doc/BRIEF.md
# Reversible Successive-Approximation Delay Controller

This block is the digital lock controller of an all-digital delay-locked loop. It drives an 11-bit control word into an external digitally controlled delay line. It reads back one bit from a phase comparator, called `tooShort`, which is 1 when the present delay is insufficient. The delay line and the phase detector sit outside the block.

Acquisition starts when `start` falls. The controller first grows the delay range from the low end: each step turns on one more low-order bit, so the range roughly doubles until the comparator reports that the delay is long enough. The step that ends this range search also decides the top bit of the final code. The remaining lower bits are then resolved one per step by a successive-approximation search. The result is the smallest control code whose delay the comparator accepts.

Decisions happen at half the reference clock rate. This gives the delay line a full reference cycle to settle before the comparator is read. One step after the last bit is decided, the controller raises `locked` and freezes the word. A range that is still short with every bit set raises `outOfRange` instead of wrapping.

Top module: `rsar_delay_ctrl`

## Requirements
- R1: While `start` is high at a rising clock edge, the word is cleared and `rangeFound`, `locked` and `outOfRange` are low after that edge.
- R2: During range search, each update on which `tooShort`=1 shifts a 1 into bit 0. The word therefore always holds its lowest K bits set, and all other bits clear.
- R3: The first update after `start` falls ignores `tooShort` and sets the word to 1 with `rangeFound` still low.
- R4: When range search sees `tooShort`=0 with the lowest K bits set, `rangeFound` rises. Bit K-1 stays 1, bit K-2 (if K≥2) is cleared, and the search continues at bit K-2.
- R5: Each search update stores `tooShort` into the bit under test (1 = keep) and clears the next lower bit, which becomes the new bit under test. The bits below it stay 1.
- R6: For a comparator that reports `tooShort`=1 exactly when the word is below a threshold T, the locked word equals the larger of T and 1, for T up to 2047.
- R7: Updates occur only on every second rising edge after `start` falls, the first on the second edge, and `tooShort` is sampled only on those edges.
- R8: `locked` rises one update after the bit-0 decision. It is seen 4K+2 rising edges after `start` falls, where K is the range width found. The worst case is 46.
- R9: Once `locked` is high, it and the word hold unchanged regardless of `tooShort` until `start` is asserted.
- R10: If `tooShort`=1 when all 11 bits are set, `outOfRange` rises 24 edges after `start` falls. The word stays all ones, and `rangeFound` and `locked` stay low.
- R11: `rangeFound` stays high from the end of range search until `start` is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| start | input | 1 | Synchronous active-high restart; acquisition begins when it falls |
| tooShort | input | 1 | Comparator result, 1 = delay insufficient |
| ctrlWord | output | 11 | Delay-line control word |
| rangeFound | output | 1 | Range search finished |
| locked | output | 1 | Search finished, word frozen |
| outOfRange | output | 1 | Full range still too short |

## Verification
The bench sweeps thresholds at the edges of the range widths: 0 and 1, the points just below and at powers of two, 2047, and one value beyond reach. A controller that miscounted the range step or decided a bit with the wrong polarity would lock one code off, or lock after the wrong number of edges. The bench runs the same thresholds with the comparator inverted on every off-phase cycle, which exposes a design that samples on the wrong half of the divider. It changes the threshold after lock, so a word that drifts is seen at once. It also restarts in the middle of a search, so stale bits that survive `start` are caught.

// File: rtl/dlyctl_pkg.sv
package dlyctl_pkg;
  parameter int unsigned CTRL_W = 11;
  localparam int unsigned SEL_W = $clog2(CTRL_W + 1);

  typedef enum logic [2:0] {
    ST_RANGE,
    ST_SAR,
    ST_SETTLE,
    ST_LOCK,
    ST_FAIL
  } seqState_t;

  typedef struct packed {
    logic             clr;
    logic             grow;
    logic             decide;
    logic             val;
    logic [SEL_W-1:0] sel;
  } wordStrb_t;
endpackage

// File: rtl/dlyctl_seq.sv
module dlyctl_seq
  import dlyctl_pkg::*;
(
  input  logic      clk,
  input  logic      start,
  input  logic      tooShort,
  output wordStrb_t strb,
  output logic      rangeFound,
  output logic      locked,
  output logic      outOfRange
);
  localparam logic [SEL_W-1:0] K_MAX = SEL_W'(CTRL_W);

  seqState_t        st;
  logic [SEL_W-1:0] kIdx;
  logic [SEL_W-1:0] bitIdx;
  logic             phase;
  logic             upd;

  assign upd = phase & ~start;

  always_ff @(posedge clk) begin
    if (start) begin
      phase      <= 1'b0;
      st         <= ST_RANGE;
      kIdx       <= '0;
      bitIdx     <= '0;
      rangeFound <= 1'b0;
    end else begin
      phase <= ~phase;
      if (upd) begin
        case (st)
          ST_RANGE: begin
            if (kIdx == '0) begin
              kIdx <= SEL_W'(1);
            end else if (tooShort) begin
              if (kIdx == K_MAX) st <= ST_FAIL;
              else kIdx <= kIdx + SEL_W'(1);
            end else begin
              rangeFound <= 1'b1;
              if (kIdx == SEL_W'(1)) begin
                st <= ST_SETTLE;
              end else begin
                st     <= ST_SAR;
                bitIdx <= kIdx - SEL_W'(2);
              end
            end
          end
          ST_SAR: begin
            if (bitIdx == '0) st <= ST_SETTLE;
            else bitIdx <= bitIdx - SEL_W'(1);
          end
          ST_SETTLE: st <= ST_LOCK;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    strb     = '0;
    strb.clr = start;
    if (upd) begin
      case (st)
        ST_RANGE: begin
          if (kIdx == '0 || (tooShort && kIdx != K_MAX)) begin
            strb.grow = 1'b1;
          end else if (!tooShort) begin
            strb.decide = 1'b1;
            strb.val    = 1'b1;
            strb.sel    = kIdx - SEL_W'(1);
          end
        end
        ST_SAR: begin
          strb.decide = 1'b1;
          strb.val    = tooShort;
          strb.sel    = bitIdx;
        end
        default: ;
      endcase
    end
  end

  assign locked     = (st == ST_LOCK);
  assign outOfRange = (st == ST_FAIL);

  AST_UPD_SPACED: assert property (@(posedge clk) disable iff (start)
    (strb.grow || strb.decide) |=> !(strb.grow || strb.decide)); // R7

  AST_SEL_BELOW_K: assert property (@(posedge clk) disable iff (start)
    (st == ST_SAR) |-> (bitIdx < kIdx)); // R5
endmodule

// File: rtl/dlyctl_word.sv
module dlyctl_word
  import dlyctl_pkg::*;
(
  input  logic              clk,
  input  wordStrb_t         strb,
  output logic [CTRL_W-1:0] word
);
  logic [CTRL_W-1:0] shiftIn;
  logic [CTRL_W-1:0] nxt;

  assign shiftIn = {word[CTRL_W-2:0], 1'b1};

  for (genvar j = 0; j < CTRL_W; j++) begin : g_bit
    assign nxt[j] = strb.clr    ? 1'b0 :
                    strb.grow   ? shiftIn[j] :
                    (strb.decide && strb.sel == SEL_W'(j))     ? strb.val :
                    (strb.decide && strb.sel == SEL_W'(j + 1)) ? 1'b0 :
                    word[j];
  end

  always_ff @(posedge clk) begin
    word <= nxt;
  end

  AST_DECIDE_STORES: assert property (@(posedge clk) disable iff (strb.clr)
    strb.decide |=> (((word >> $past(strb.sel)) & CTRL_W'(1)) == CTRL_W'($past(strb.val)))); // R5

  AST_GROW_SETS_LSB: assert property (@(posedge clk) disable iff (strb.clr)
    strb.grow |=> word[0]); // R2
endmodule

// File: rtl/rsar_delay_ctrl.sv
module rsar_delay_ctrl
  import dlyctl_pkg::*;
(
  input  logic              clk,
  input  logic              start,
  input  logic              tooShort,
  output logic [CTRL_W-1:0] ctrlWord,
  output logic              rangeFound,
  output logic              locked,
  output logic              outOfRange
);
  wordStrb_t strb;

  dlyctl_seq u_seq (
    .clk        (clk),
    .start      (start),
    .tooShort   (tooShort),
    .strb       (strb),
    .rangeFound (rangeFound),
    .locked     (locked),
    .outOfRange (outOfRange)
  );

  dlyctl_word u_word (
    .clk  (clk),
    .strb (strb),
    .word (ctrlWord)
  );

  AST_START_CLEARS: assert property (@(posedge clk)
    start |=> (ctrlWord == '0 && !rangeFound && !locked && !outOfRange)); // R1

  AST_RANGE_SHAPE: assert property (@(posedge clk) disable iff (start)
    !rangeFound |-> ((ctrlWord & (ctrlWord + CTRL_W'(1))) == '0)); // R2

  AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (start)
    locked |=> (locked && $stable(ctrlWord))); // R9

  AST_FULL_ON_ERR: assert property (@(posedge clk) disable iff (start)
    outOfRange |-> (ctrlWord == '1 && !rangeFound && !locked)); // R10

  AST_FOUND_STICKY: assert property (@(posedge clk) disable iff (start)
    rangeFound |=> rangeFound); // R11

  AST_LOCK_AFTER_FOUND: assert property (@(posedge clk) disable iff (start)
    locked |-> rangeFound); // R8
endmodule

// File: tb/rsar_delay_ctrl_bench.sv
module rsar_delay_ctrl_bench;
  localparam int W = 11;
  localparam int FULL = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         start = 1'b1;
  logic         tooShort;
  logic [W-1:0] ctrlWord;
  logic         rangeFound, locked, outOfRange;

  int  thr = 0;
  bit  noise = 1'b0;
  bit  chkOn = 1'b0;
  int  total = 0;
  int  bad = 0;
  int  cyc = 0;
  bit  done = 1'b0;

  // reference model state
  bit mPhase;
  int mWord, mK, mStage, mBit, mHi;
  bit mFound;

  always #10 clk = ~clk;

  assign tooShort = (int'(ctrlWord) < thr) ^ (noise & ~mPhase);

  rsar_delay_ctrl u_rsar_delay_ctrl (
    .clk(clk), .start(start), .tooShort(tooShort), .ctrlWord(ctrlWord),
    .rangeFound(rangeFound), .locked(locked), .outOfRange(outOfRange)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // stage: 0 range, 1 search, 2 settle, 3 locked, 4 error
  always @(posedge clk) begin
    if (start) begin
      mPhase <= 1'b0; mWord <= 0; mK <= 0; mStage <= 0; mFound <= 1'b0; mBit <= 0; mHi <= 0;
    end else begin
      mPhase <= !mPhase;
      if (mPhase) begin
        case (mStage)
          0: begin
            if (mK == 0) begin
              mWord <= 1; mK <= 1;
            end else if (mWord < thr) begin
              if (mK == W) mStage <= 4;
              else begin mWord <= mWord * 2 + 1; mK <= mK + 1; end
            end else begin
              mFound <= 1'b1;
              mHi <= mWord;
              if (mK == 1) mStage <= 2;
              else begin
                mStage <= 1; mBit <= mK - 2; mWord <= mWord - (1 << (mK - 2));
              end
            end
          end
          1: begin
            int hiN;
            hiN = (mWord >= thr) ? mWord : mHi;
            mHi <= hiN;
            if (mBit == 0) begin mWord <= hiN; mStage <= 2; end
            else begin mWord <= hiN - (1 << (mBit - 1)); mBit <= mBit - 1; end
          end
          2: mStage <= 3;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (chkOn && !done) begin
      chk(int'(ctrlWord) == mWord, "R5", "word vs model", int'(ctrlWord), mWord);
      chk(rangeFound == mFound, "R4", "rangeFound vs model", rangeFound, mFound);
      chk(locked == (mStage == 3), "R8", "locked vs model", locked, mStage == 3);
      chk(outOfRange == (mStage == 4), "R10", "outOfRange vs model", outOfRange, mStage == 4);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      chk(1'b0, "R8", "watchdog expired", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int kNeed(input int t);
    int k = 1;
    while (((1 << k) - 1) < t && k <= W) k++;
    return k;
  endfunction

  task automatic runCase(input int t, input bit nz);
    int k, n, expN, expW;
    bit expErr;
    k = kNeed(t);
    expErr = (k > W);
    expN = expErr ? 24 : 4 * k + 2;
    expW = expErr ? FULL : ((t < 1) ? 1 : t);
    @(negedge clk);
    start = 1'b1; thr = t; noise = nz;
    repeat (2) @(negedge clk);
    chk(ctrlWord == '0 && !rangeFound && !locked && !outOfRange, "R1", "reset state", int'(ctrlWord), 0);
    start = 1'b0;
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 1) chk(ctrlWord == '0, "R7", "no update on first edge", int'(ctrlWord), 0);
      if (n == 2) chk(ctrlWord == W'(1) && !rangeFound, "R3", "first update forces 1", int'(ctrlWord), 1);
    end while (!locked && !outOfRange && n < 200);
    if (expErr) begin
      chk(outOfRange == 1'b1, "R10", "error flag", outOfRange, 1);
      chk(n == expN, "R10", "error time", n, expN);
      chk(int'(ctrlWord) == FULL && !rangeFound, "R10", "word held full", int'(ctrlWord), FULL);
    end else begin
      chk(n == expN, "R8", "lock time", n, expN);
      chk(int'(ctrlWord) == expW, "R6", "locked word", int'(ctrlWord), expW);
      chk(rangeFound == 1'b1, "R11", "found held at lock", rangeFound, 1);
      thr = (t == 0) ? 2047 : 0;
      repeat (6) @(negedge clk);
      chk(locked && int'(ctrlWord) == expW, "R9", "frozen after lock", int'(ctrlWord), expW);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chkOn = 1'b1;
    runCase(0, 1'b0);
    runCase(1, 1'b0);
    runCase(2, 1'b0);
    runCase(5, 1'b1);
    runCase(700, 1'b0);
    runCase(700, 1'b1);
    runCase(1023, 1'b0);
    runCase(1024, 1'b1);
    runCase(1500, 1'b0);
    runCase(2047, 1'b0);
    runCase(2047, 1'b1);
    runCase(2048, 1'b0);
    // restart in the middle of a search
    @(negedge clk);
    start = 1'b1; thr = 1500; noise = 1'b0;
    repeat (2) @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    chk(rangeFound == 1'b1, "R11", "found before restart", rangeFound, 1);
    start = 1'b1;
    @(negedge clk);
    chk(ctrlWord == '0 && !rangeFound && !locked && !outOfRange, "R1", "mid-search restart", int'(ctrlWord), 0);
    runCase(333, 1'b1);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule